// File: doc/BRIEF.md
# VGA Raster Timing and Blanking Generator

This block produces the horizontal and vertical timing for a 640x480, 60 Hz raster from a 50 MHz system clock. Within the 50 MHz domain it makes a pixel-rate enable that is high on every other clock, which gives a 25 MHz pixel rate without a second clock. A pixel counter steps on each enabled cycle and a line counter steps each time the pixel counter wraps. From the two counts it decodes the four phases of each scan period. In time order these are the sync pulse, the back porch, the visible interval and the front porch.

The sync outputs are active low. The colour outputs take three static 2-bit switch values. They are forced to zero whenever the beam is outside the visible area, so they are zero in both porches and during sync. A display-enable flag and the x/y position within the visible area are also given. All outputs come from one register stage, so they stay aligned with each other. Every phase length is a parameter. The defaults give 96/48/640/16 pixel clocks per line (800 in total) and 2/33/480/10 lines per frame (525 in total).

Top module: `vga_timing_top`

## Requirements
- R1: After reset is released, the internal pixel enable is high on alternate clock cycles. Counters and outputs change only on clock edges where it is high.
- R2: The pixel count runs from 0 to H_SYNC+H_BACK+H_ACTIVE+H_FRONT-1 and then returns to 0.
- R3: The line count advances by one only on the enabled edge where the pixel count wraps, and holds its value otherwise.
- R4: The line count runs from 0 to V_SYNC+V_BACK+V_ACTIVE+V_FRONT-1 and then returns to 0, which starts a new frame.
- R5: hsync_n is 0 exactly while the pixel count is below H_SYNC. This is the first phase of the line. Back porch, then display, then front porch follow it.
- R6: vsync_n is 0 exactly while the line count is below V_SYNC. Vertical back porch, display and front porch follow in that order.
- R7: disp_en is 1 exactly when the pixel count lies in [H_SYNC+H_BACK, H_SYNC+H_BACK+H_ACTIVE) and the line count lies in the matching vertical window. red/grn/blu then equal sw_red/sw_grn/sw_blu as sampled on that enabled edge. At all other times the three colour outputs are 0.
- R8: While disp_en is 1, pix_x equals the pixel count minus (H_SYNC+H_BACK) and pix_y equals the line count minus (V_SYNC+V_BACK). While disp_en is 0, both are 0.
- R9: While rst_n is low, the following hold: hsync_n=1, vsync_n=1, red/grn/blu=0, disp_en=0 and pix_x=pix_y=0. Both counters and the enable are cleared.
- R10: All outputs are registered together. After the second rising clock edge following reset release, the enable first rises on the third edge. On the fourth edge the outputs first show the state of pixel 0 of line 0. From then on, the outputs after edge 4+2k show the raster position k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_red | input | COLOR_W | Static red value |
| sw_grn | input | COLOR_W | Static green value |
| sw_blu | input | COLOR_W | Static blue value |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | COLOR_W | Gated red channel |
| grn | output | COLOR_W | Gated green channel |
| blu | output | COLOR_W | Gated blue channel |
| disp_en | output | 1 | High inside the visible area |
| pix_x | output | XW | Column within the visible area |
| pix_y | output | YW | Row within the visible area |

## Verification
The delicate coincidence is the end of a line that is also the end of a frame. On that enabled edge the pixel counter and the line counter both wrap. At the same edge the hsync and vsync phases re-enter sync, and the visible window closes on both axes. Several complete frames are run with small phase lengths, so that every line wrap and frame wrap is crossed many times. The switch inputs change at a stride that is prime relative to the line length, so colour changes land at visible-area boundaries and inside the porches. Each output is compared on every cycle against the raster position, which is computed by division from the number of edges since reset release.

// File: rtl/vga_timing_pkg.sv
package vga_timing_pkg;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_DISP  = 2'd2,
    PH_FRONT = 2'd3
  } scan_phase_e;

  function automatic int unsigned off_width(input int unsigned active);
    return (active > 1) ? $clog2(active) : 1;
  endfunction

endpackage

// File: rtl/vga_rst_sync.sv
module vga_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/vga_pix_enable.sv
module vga_pix_enable (
  input  logic clk,
  input  logic rst_n,
  output logic pix_en
);

  logic en_q;
  logic en_d;

  always_comb begin
    en_d = ~en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign pix_en = en_q;

  AST_EN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> !pix_en); // R1
  AST_EN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> pix_en); // R1

endmodule

// File: rtl/vga_scan_axis.sv
module vga_scan_axis
  import vga_timing_pkg::*;
#(
  parameter int unsigned SYNC_LEN  = 96,
  parameter int unsigned BACK_LEN  = 48,
  parameter int unsigned ACT_LEN   = 640,
  parameter int unsigned FRONT_LEN = 16,
  localparam int unsigned TOTAL    = SYNC_LEN + BACK_LEN + ACT_LEN + FRONT_LEN,
  localparam int unsigned CW       = $clog2(TOTAL),
  localparam int unsigned OW       = off_width(ACT_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic          wrap,
  output scan_phase_e   phase,
  output logic [OW-1:0] offset
);

  localparam logic [CW-1:0] LAST      = CW'(TOTAL - 1);
  localparam logic [CW-1:0] BACK_AT   = CW'(SYNC_LEN);
  localparam logic [CW-1:0] DISP_AT   = CW'(SYNC_LEN + BACK_LEN);
  localparam logic [CW-1:0] FRONT_AT  = CW'(SYNC_LEN + BACK_LEN + ACT_LEN);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] rel;

  always_comb begin
    wrap  = step && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (step) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    if (cnt_q < BACK_AT) begin
      phase = PH_SYNC;
    end else if (cnt_q < DISP_AT) begin
      phase = PH_BACK;
    end else if (cnt_q < FRONT_AT) begin
      phase = PH_DISP;
    end else begin
      phase = PH_FRONT;
    end
    rel    = cnt_q - DISP_AT;
    offset = rel[OW-1:0];
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == LAST) |=> (cnt_q == '0)); // R4
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q)); // R3
  AST_SYNC_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase == PH_SYNC) |=> (phase == PH_SYNC || phase == PH_BACK)); // R5
  AST_FRONT_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase == PH_FRONT) |=> (phase == PH_FRONT || phase == PH_SYNC)); // R6

endmodule

// File: rtl/vga_out_stage.sv
module vga_out_stage
  import vga_timing_pkg::*;
#(
  parameter int unsigned COLOR_W = 2,
  parameter int unsigned XW      = 10,
  parameter int unsigned YW      = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pix_en,
  input  scan_phase_e                h_phase,
  input  scan_phase_e                v_phase,
  input  logic [XW-1:0]              h_off,
  input  logic [YW-1:0]              v_off,
  input  logic [2:0][COLOR_W-1:0]    sw_rgb,
  output logic                       hsync_n,
  output logic                       vsync_n,
  output logic                       disp_en,
  output logic [2:0][COLOR_W-1:0]    rgb,
  output logic [XW-1:0]              pix_x,
  output logic [YW-1:0]              pix_y
);

  logic                    hs_d, vs_d, de_d;
  logic [XW-1:0]           x_d;
  logic [YW-1:0]           y_d;
  logic [2:0][COLOR_W-1:0] rgb_d;

  logic                    hs_q, vs_q, de_q;
  logic [XW-1:0]           x_q;
  logic [YW-1:0]           y_q;
  logic [2:0][COLOR_W-1:0] rgb_q;

  always_comb begin
    hs_d = hs_q;
    vs_d = vs_q;
    de_d = de_q;
    x_d  = x_q;
    y_d  = y_q;
    if (pix_en) begin
      hs_d = (h_phase != PH_SYNC);
      vs_d = (v_phase != PH_SYNC);
      de_d = (h_phase == PH_DISP) && (v_phase == PH_DISP);
      x_d  = de_d ? h_off : '0;
      y_d  = de_d ? v_off : '0;
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_chan
    always_comb begin
      rgb_d[c] = rgb_q[c];
      if (pix_en) begin
        rgb_d[c] = de_d ? sw_rgb[c] : '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rgb_q[c] <= '0;
      end else begin
        rgb_q[c] <= rgb_d[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
      vs_q <= 1'b1;
      de_q <= 1'b0;
      x_q  <= '0;
      y_q  <= '0;
    end else begin
      hs_q <= hs_d;
      vs_q <= vs_d;
      de_q <= de_d;
      x_q  <= x_d;
      y_q  <= y_d;
    end
  end

  assign hsync_n = hs_q;
  assign vsync_n = vs_q;
  assign disp_en = de_q;
  assign rgb     = rgb_q;
  assign pix_x   = x_q;
  assign pix_y   = y_q;

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> (rgb == '0)); // R7
  AST_XY_ZERO_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> (pix_x == '0 && pix_y == '0)); // R8
  AST_HSYNC_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> !disp_en); // R5
  AST_VSYNC_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> !disp_en); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable({hsync_n, vsync_n, disp_en, rgb, pix_x, pix_y})); // R10

endmodule

// File: rtl/vga_timing_top.sv
module vga_timing_top
  import vga_timing_pkg::*;
#(
  parameter int unsigned H_SYNC   = 96,
  parameter int unsigned H_BACK   = 48,
  parameter int unsigned H_ACTIVE = 640,
  parameter int unsigned H_FRONT  = 16,
  parameter int unsigned V_SYNC   = 2,
  parameter int unsigned V_BACK   = 33,
  parameter int unsigned V_ACTIVE = 480,
  parameter int unsigned V_FRONT  = 10,
  parameter int unsigned COLOR_W  = 2,
  localparam int unsigned XW      = off_width(H_ACTIVE),
  localparam int unsigned YW      = off_width(V_ACTIVE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COLOR_W-1:0] sw_red,
  input  logic [COLOR_W-1:0] sw_grn,
  input  logic [COLOR_W-1:0] sw_blu,
  output logic               hsync_n,
  output logic               vsync_n,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] grn,
  output logic [COLOR_W-1:0] blu,
  output logic               disp_en,
  output logic [XW-1:0]      pix_x,
  output logic [YW-1:0]      pix_y
);

  logic                    rst_i_n;
  logic                    pix_en;
  logic                    h_wrap;
  logic                    v_wrap;
  scan_phase_e             h_phase;
  scan_phase_e             v_phase;
  logic [XW-1:0]           h_off;
  logic [YW-1:0]           v_off;
  logic [2:0][COLOR_W-1:0] sw_rgb;
  logic [2:0][COLOR_W-1:0] rgb;

  assign sw_rgb = {sw_red, sw_grn, sw_blu};

  vga_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  vga_pix_enable u_en (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .pix_en (pix_en)
  );

  vga_scan_axis #(
    .SYNC_LEN  (H_SYNC),
    .BACK_LEN  (H_BACK),
    .ACT_LEN   (H_ACTIVE),
    .FRONT_LEN (H_FRONT)
  ) u_hax (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .step   (pix_en),
    .wrap   (h_wrap),
    .phase  (h_phase),
    .offset (h_off)
  );

  vga_scan_axis #(
    .SYNC_LEN  (V_SYNC),
    .BACK_LEN  (V_BACK),
    .ACT_LEN   (V_ACTIVE),
    .FRONT_LEN (V_FRONT)
  ) u_vax (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .step   (h_wrap),
    .wrap   (v_wrap),
    .phase  (v_phase),
    .offset (v_off)
  );

  vga_out_stage #(
    .COLOR_W (COLOR_W),
    .XW      (XW),
    .YW      (YW)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .pix_en  (pix_en),
    .h_phase (h_phase),
    .v_phase (v_phase),
    .h_off   (h_off),
    .v_off   (v_off),
    .sw_rgb  (sw_rgb),
    .hsync_n (hsync_n),
    .vsync_n (vsync_n),
    .disp_en (disp_en),
    .rgb     (rgb),
    .pix_x   (pix_x),
    .pix_y   (pix_y)
  );

  assign red = rgb[2];
  assign grn = rgb[1];
  assign blu = rgb[0];

  AST_LINE_WRAP_ONLY_ON_PIXEL_WRAP: assert property (@(posedge clk) disable iff (!rst_i_n)
    v_wrap |-> (h_wrap && pix_en)); // R3

endmodule

// File: tb/tb_vga_timing_top.sv
module tb_vga_timing_top;

  localparam int HS = 3, HB = 2, HA = 5, HF = 2;
  localparam int VS = 2, VB = 1, VA = 3, VF = 2;
  localparam int HT = HS + HB + HA + HF;
  localparam int VT = VS + VB + VA + VF;
  localparam int XW = $clog2(HA);
  localparam int YW = $clog2(VA);

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] sw_red, sw_grn, sw_blu;
  logic hsync_n, vsync_n, disp_en;
  logic [1:0] red, grn, blu;
  logic [XW-1:0] pix_x;
  logic [YW-1:0] pix_y;

  int vectors = 0;
  int errors  = 0;
  logic [5:0] sw_cap;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  vga_timing_top #(
    .H_SYNC(HS), .H_BACK(HB), .H_ACTIVE(HA), .H_FRONT(HF),
    .V_SYNC(VS), .V_BACK(VB), .V_ACTIVE(VA), .V_FRONT(VF),
    .COLOR_W(2)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .sw_red(sw_red), .sw_grn(sw_grn), .sw_blu(sw_blu),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .red(red), .grn(grn), .blu(blu),
    .disp_en(disp_en), .pix_x(pix_x), .pix_y(pix_y)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_reset_vals(input string req);
    cmp(req, "hsync_n", int'(hsync_n), 1);
    cmp(req, "vsync_n", int'(vsync_n), 1);
    cmp(req, "rgb", int'({red, grn, blu}), 0);
    cmp(req, "disp_en", int'(disp_en), 0);
    cmp(req, "pix_x", int'(pix_x), 0);
    cmp(req, "pix_y", int'(pix_y), 0);
  endtask

  // n = rising edges since reset release
  task automatic check_pos(input int n);
    int p, h, v, x, y;
    bit hd, vd, de;
    if (n < 4) begin
      check_reset_vals("R10");
      return;
    end
    p  = (n - 4) / 2;
    h  = p % HT;
    v  = (p / HT) % VT;
    hd = (h >= HS + HB) && (h < HS + HB + HA);
    vd = (v >= VS + VB) && (v < VS + VB + VA);
    de = hd && vd;
    x  = de ? h - HS - HB : 0;
    y  = de ? v - VS - VB : 0;
    cmp("R5", "hsync_n", int'(hsync_n), (h < HS) ? 0 : 1);
    cmp("R6", "vsync_n", int'(vsync_n), (v < VS) ? 0 : 1);
    cmp("R7", "disp_en", int'(disp_en), int'(de));
    cmp("R7", "rgb", int'({red, grn, blu}), de ? int'(sw_cap) : 0);
    cmp("R8", "pix_x", int'(pix_x), x);
    cmp("R8", "pix_y", int'(pix_y), y);
  endtask

  task automatic run_cycles(input int cycles, input int seed);
    logic [5:0] pat = 6'(seed);
    for (int n = 1; n <= cycles && !done; n++) begin
      @(posedge clk);
      if (n >= 4 && ((n - 4) % 2) == 0) sw_cap = {sw_red, sw_grn, sw_blu};
      @(negedge clk);
      check_pos(n);  // R1 R2 R3 R4 covered by position arithmetic
      if ((n % 7) == 0) begin
        pat = pat * 6'd5 + 6'd23;
        {sw_red, sw_grn, sw_blu} = pat;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    {sw_red, sw_grn, sw_blu} = 6'b111111;
    sw_cap = '0;
    repeat (3) @(negedge clk);
    check_reset_vals("R9");
    rst_n = 1'b1;
    // several frames: line wrap and frame wrap coincide repeatedly (R2 R3 R4)
    run_cycles(2 * HT * VT * 3 + 40, 11);
    // reset in mid-frame
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_vals("R9");
    repeat (4) @(negedge clk);
    check_reset_vals("R9");
    {sw_red, sw_grn, sw_blu} = 6'b101101;
    rst_n = 1'b1;
    run_cycles(2 * HT * VT * 2 + 9, 37); // R1 restart timing
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule